// File: doc/BRIEF.md
# Timed receive streaming command controller

This block sits in front of one receive sample chain and decides which of the chain's sample strobes are passed downstream. Software describes a streaming burst with three writes on a narrow settings bus. The first write is a command word holding a start-now flag, a link-to-next flag and a sample count. The second and third writes are the upper (seconds) and lower (ticks) halves of a 64-bit start time. Only the third write turns the staged words into a command, and that command is appended to a small queue.

The command at the head of the queue either starts at once or waits for the free-running local time to reach its start time. While it runs, every strobe from the sample chain is forwarded as a valid sample until the requested count is used up. Linked commands follow each other with no idle cycle, and a start-now command with a count of zero ends a linked stream. Three sticky flags report a start time that had already passed, a linked command that found the queue empty, and a sample that the downstream side was not ready to take.

A system with two receive channels uses two copies of the block, each placed at its own base address on the shared settings bus.

Top module: `rx_stream_sched`

## Requirements
- R1: Writes are decoded relative to parameter BASE_ADDR (default 176): offset 0 is the command word, offset 1 the seconds word and offset 2 the ticks word. Writes to any other address change neither the staged words nor the queue.
- R2: In the command word, bit 31 is the start-now flag, bit 30 is the link-to-next flag, and bits 29:0 are the sample count.
- R3: A write to offset 2 latches {command word, staged seconds, written ticks} into a 4-entry FIFO. If the FIFO already holds 4 commands, the new command is dropped.
- R4: A start-now head command with count N>0 is taken one cycle after it reaches the head. From the following cycle, streaming is high and exactly N strobes are forwarded, after which streaming falls.
- R5: A timed command has the start time {seconds, ticks}. It stays queued (streaming low) while now_time is below that time, and it is taken on the first cycle in which now_time is equal to or greater than it.
- R6: A timed command whose start time is already below now_time on its first cycle at the head is removed without producing samples, and err_late is set.
- R7: A start-now command with count 0 is removed, produces no samples and leaves streaming low. When it is taken as the next linked command, it ends the stream.
- R8: When the last sample of a linked command is forwarded and the queue is not empty, the head command is taken in the same cycle, whatever its start time. Streaming stays high with no gap.
- R9: When the last sample of a linked command is forwarded and the queue is empty, err_underflow is set and streaming stops.
- R10: A strobe that arrives while streaming and while dn_ready is low sets the sticky err_overrun and is not forwarded. Streaming stops, and no queued command is taken until the next ticks write.
- R11: Any write to offset 2 clears all three error flags. A flag set in the same cycle stays set.
- R12: dn_valid is high exactly when streaming, dsp_stb and dn_ready are all high.
- R13: After a synchronous reset the queue is empty, streaming, dn_valid and all error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_stb | input | 1 | Settings-bus write strobe |
| cfg_addr | input | 8 | Settings-bus write address |
| cfg_data | input | 32 | Settings-bus write data |
| now_time | input | 64 | Local time, seconds in the upper half, ticks in the lower half |
| dsp_stb | input | 1 | Sample strobe from the receive chain |
| dn_ready | input | 1 | Downstream can accept a sample |
| dn_valid | output | 1 | Forwarded sample strobe |
| streaming | output | 1 | A command is active |
| err_late | output | 1 | Sticky: a timed command arrived too late |
| err_underflow | output | 1 | Sticky: a linked command found no successor |
| err_overrun | output | 1 | Sticky: a sample was lost to a not-ready downstream |

## Verification
The bench covers several failure modes:
- Start times that cross the 32-bit ticks boundary: a design that compared only one half of the time would start early or never.
- A start time equal to the current time against one just past it: an off-by-one comparison would flag a good command as late or run a stale one.
- A linked pair followed by nothing, and a linked command followed by a stop command: dropping the link would leave a one-cycle hole, and the wrong stop handling would raise a false underflow or stream forever.
- A fifth command written into a full queue, and writes to the other channel's addresses: a design that overwrote queue entries or decoded too few address bits would produce extra samples.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
   // Register offsets; the ticks offset is the one that commits a command.
   localparam int OFS_CMD  = 0;
   localparam int OFS_SEC  = 1;
   localparam int OFS_TICK = 2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RUN  = 2'd2
   } sched_st_e;
endpackage

// File: rtl/rxs_regs.sv
module rxs_regs #(
   parameter int AW        = 8,
   parameter int DW        = 32,
   parameter int CNT_W     = 30,
   parameter int BASE_ADDR = 176,
   localparam int TIME_W   = 2 * DW,
   localparam int ENTRY_W  = 2 + CNT_W + TIME_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_stb,
   input  logic [AW-1:0]      wr_addr,
   input  logic [DW-1:0]      wr_data,
   output logic               latch,
   output logic [ENTRY_W-1:0] entry
);
   import rxs_pkg::*;

   localparam logic [AW-1:0] A_CMD  = AW'(BASE_ADDR + OFS_CMD);
   localparam logic [AW-1:0] A_SEC  = AW'(BASE_ADDR + OFS_SEC);
   localparam logic [AW-1:0] A_TICK = AW'(BASE_ADDR + OFS_TICK);

   logic [CNT_W+1:0] cmd_q;
   logic [DW-1:0]    sec_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_q <= '0;
         sec_q <= '0;
      end else if (wr_stb) begin
         if (wr_addr == A_CMD)
            cmd_q <= {wr_data[DW-1], wr_data[DW-2], wr_data[CNT_W-1:0]};
         if (wr_addr == A_SEC)
            sec_q <= wr_data;
      end
   end

   assign latch = wr_stb && (wr_addr == A_TICK);
   assign entry = {cmd_q, sec_q, wr_data};

   // R1: staging words move only on their own address
   p_stage_hold_r1: assert property (@(posedge clk) disable iff (rst)
      !(wr_stb && wr_addr == A_CMD) |=> $stable(cmd_q));
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
   parameter int W     = 96,
   parameter int DEPTH = 4,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr,
   input  logic [W-1:0] wr_data,
   input  logic         rd,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          do_wr, do_rd;

   assign empty = (cnt == '0);
   assign full  = (cnt == FULL_CNT);
   assign do_wr = wr && !full;
   assign do_rd = rd && !empty;
   assign head  = mem[rp];

   // Pointer advance: natural wrap for a power-of-two depth, compare otherwise.
   function automatic logic [PW-1:0] nxt_ptr(input logic [PW-1:0] p);
      return p + PW'(1);
   endfunction

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         always_ff @(posedge clk) begin
            if (rst) begin
               wp <= '0;
               rp <= '0;
            end else begin
               if (do_wr) wp <= nxt_ptr(wp);
               if (do_rd) rp <= nxt_ptr(rp);
            end
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (rst) begin
               wp <= '0;
               rp <= '0;
            end else begin
               if (do_wr) wp <= (wp == LAST_IDX) ? '0 : nxt_ptr(wp);
               if (do_rd) rp <= (rp == LAST_IDX) ? '0 : nxt_ptr(rp);
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (do_wr && !do_rd)
         cnt <= cnt + CW'(1);
      else if (do_rd && !do_wr)
         cnt <= cnt - CW'(1);
   end

   // R3: a write into a full queue leaves it full, not wrapped
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      (full && wr && !rd) |=> full);
   // R8: the scheduler never pops an empty queue
   p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (rst)
      rd |-> !empty);
endmodule

// File: rtl/rxs_sched.sv
module rxs_sched #(
   parameter int CNT_W  = 30,
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hd_now,
   input  logic              hd_link,
   input  logic [CNT_W-1:0]  hd_cnt,
   input  logic [TIME_W-1:0] hd_time,
   input  logic              q_empty,
   input  logic [TIME_W-1:0] now_time,
   input  logic              latch,
   input  logic              samp_stb,
   input  logic              samp_ready,
   output logic              q_pop,
   output logic              samp_valid,
   output logic              streaming,
   output logic              err_late,
   output logic              err_underflow,
   output logic              err_overrun
);
   import rxs_pkg::*;

   sched_st_e        state, nxt_state;
   logic [CNT_W-1:0] rem;
   logic             link;
   logic             take, dec;
   logic             set_late, set_unf, set_ovr;
   logic             due, past;

   assign due  = (now_time >= hd_time);
   assign past = (now_time > hd_time);

   always_comb begin
      nxt_state = state;
      take      = 1'b0;
      dec       = 1'b0;
      set_late  = 1'b0;
      set_unf   = 1'b0;
      set_ovr   = 1'b0;
      q_pop     = 1'b0;
      case (state)
         ST_IDLE, ST_WAIT: begin
            if (!err_overrun && !q_empty) begin
               if (hd_now)
                  take = 1'b1;
               else if (state == ST_IDLE && past) begin
                  q_pop     = 1'b1;
                  set_late  = 1'b1;
                  nxt_state = ST_IDLE;
               end else if (due)
                  take = 1'b1;
               else
                  nxt_state = ST_WAIT;
            end
         end
         ST_RUN: begin
            if (samp_stb) begin
               if (!samp_ready) begin
                  set_ovr   = 1'b1;
                  nxt_state = ST_IDLE;
               end else if (rem == CNT_W'(1)) begin
                  nxt_state = ST_IDLE;
                  if (link) begin
                     if (!q_empty) take = 1'b1;
                     else          set_unf = 1'b1;
                  end
               end else
                  dec = 1'b1;
            end
         end
         default: nxt_state = ST_IDLE;
      endcase
      if (take) begin
         q_pop     = 1'b1;
         nxt_state = (hd_cnt != '0) ? ST_RUN : ST_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         rem   <= '0;
         link  <= 1'b0;
      end else begin
         state <= nxt_state;
         if (take) begin
            rem  <= hd_cnt;
            link <= hd_link;
         end else if (dec)
            rem <= rem - CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         err_late      <= 1'b0;
         err_underflow <= 1'b0;
         err_overrun   <= 1'b0;
      end else begin
         err_late      <= (err_late      && !latch) || set_late;
         err_underflow <= (err_underflow && !latch) || set_unf;
         err_overrun   <= (err_overrun   && !latch) || set_ovr;
      end
   end

   assign streaming  = (state == ST_RUN);
   assign samp_valid = streaming && samp_stb && samp_ready;

   // R4: an active command always has samples left
   p_run_left_r4: assert property (@(posedge clk) disable iff (rst)
      (state == ST_RUN) |-> (rem != '0));
   // R5: a timed command before its start time keeps waiting
   p_wait_early_r5: assert property (@(posedge clk) disable iff (rst)
      (state == ST_WAIT && !past && !due) |=> (state == ST_WAIT));
   // R6: a late drop never starts a stream
   p_late_idle_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(err_late) |-> (state == ST_IDLE));
   // R10: an overrun halts the stream in the same cycle it is flagged
   p_ovr_halt_r10: assert property (@(posedge clk) disable iff (rst)
      $rose(err_overrun) |-> (state == ST_IDLE));
endmodule

// File: rtl/rx_stream_sched.sv
module rx_stream_sched #(
   parameter int AW        = 8,
   parameter int DW        = 32,
   parameter int CNT_W     = 30,
   parameter int DEPTH     = 4,
   parameter int BASE_ADDR = 176,
   localparam int TIME_W   = 2 * DW,
   localparam int ENTRY_W  = 2 + CNT_W + TIME_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_stb,
   input  logic [AW-1:0]     cfg_addr,
   input  logic [DW-1:0]     cfg_data,
   input  logic [TIME_W-1:0] now_time,
   input  logic              dsp_stb,
   input  logic              dn_ready,
   output logic              dn_valid,
   output logic              streaming,
   output logic              err_late,
   output logic              err_underflow,
   output logic              err_overrun
);
   initial begin
      assert (CNT_W >= 1 && CNT_W <= DW - 2) else $fatal(1, "CNT_W out of range");
      assert (DEPTH >= 2) else $fatal(1, "DEPTH must be at least 2");
      assert (BASE_ADDR + 2 < (1 << AW)) else $fatal(1, "BASE_ADDR too high");
   end

   logic               latch, q_empty, q_full, q_pop;
   logic [ENTRY_W-1:0] entry, head;

   rxs_regs #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .BASE_ADDR(BASE_ADDR)) i_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_stb  (cfg_stb),
      .wr_addr (cfg_addr),
      .wr_data (cfg_data),
      .latch   (latch),
      .entry   (entry)
   );

   rxs_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) i_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr      (latch),
      .wr_data (entry),
      .rd      (q_pop),
      .head    (head),
      .empty   (q_empty),
      .full    (q_full)
   );

   rxs_sched #(.CNT_W(CNT_W), .TIME_W(TIME_W)) i_sched (
      .clk           (clk),
      .rst           (rst),
      .hd_now        (head[ENTRY_W-1]),
      .hd_link       (head[ENTRY_W-2]),
      .hd_cnt        (head[TIME_W +: CNT_W]),
      .hd_time       (head[TIME_W-1:0]),
      .q_empty       (q_empty),
      .now_time      (now_time),
      .latch         (latch),
      .samp_stb      (dsp_stb),
      .samp_ready    (dn_ready),
      .q_pop         (q_pop),
      .samp_valid    (dn_valid),
      .streaming     (streaming),
      .err_late      (err_late),
      .err_underflow (err_underflow),
      .err_overrun   (err_overrun)
   );

   // R11: a ticks write clears a flag unless it is raised again
   p_flag_clear_r11: assert property (@(posedge clk) disable iff (rst)
      (latch && !q_full && err_underflow && !streaming) |=> !err_underflow);
   // R12: a forwarded sample needs a ready downstream
   p_valid_ready_r12: assert property (@(posedge clk) disable iff (rst)
      dn_valid |-> (dn_ready && streaming));
endmodule

// File: tb/test_rx_stream_sched.sv
`timescale 1ns/1ps
module test_rx_stream_sched;
   localparam int BASE = 176;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_stb = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_data = '0;
   logic [63:0] now_time = 64'h0000_0004_FFFF_FFC0;
   logic        dsp_stb = 1'b0;
   logic        dn_ready = 1'b1;
   logic        dn_valid, streaming, err_late, err_underflow, err_overrun;

   int n_chk = 0;
   int n_fail = 0;
   int nvalid = 0;
   string cur_req = "R13";

   always #2 clk = ~clk;
   always @(posedge clk) now_time <= now_time + 64'd1;

   rx_stream_sched i_rx_stream_sched (
      .clk(clk), .rst(rst), .cfg_stb(cfg_stb), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
      .now_time(now_time), .dsp_stb(dsp_stb), .dn_ready(dn_ready), .dn_valid(dn_valid),
      .streaming(streaming), .err_late(err_late), .err_underflow(err_underflow),
      .err_overrun(err_overrun));

   // ---------------- behavioural reference model ----------------
   typedef struct {
      bit              imm;
      bit              lnk;
      int unsigned     cnt;
      longint unsigned t;
   } mcmd_t;

   mcmd_t           mq[$];
   int              mst = 0;   // 0 idle, 1 waiting, 2 running
   int unsigned     mrem = 0;
   bit              mlnk = 0;
   bit              mlate = 0, munf = 0, movr = 0;
   bit [31:0]       mcmdw = 0, msec = 0;

   task automatic m_take();
      mcmd_t h;
      h = mq.pop_front();
      if (h.cnt != 0) begin mst = 2; mrem = h.cnt; mlnk = h.lnk; end
      else mst = 0;
   endtask

   always @(posedge clk) begin
      if (rst) begin
         mq.delete(); mst = 0; mrem = 0; mlnk = 0;
         mlate = 0; munf = 0; movr = 0; mcmdw = 0; msec = 0;
      end else begin
         bit lat, was_full, s_late, s_unf, s_ovr;
         longint unsigned now;
         now = now_time;
         lat = cfg_stb && cfg_addr == 8'(BASE + 2);
         was_full = (mq.size() == 4);
         s_late = 0; s_unf = 0; s_ovr = 0;
         if (mst == 2) begin
            if (dsp_stb) begin
               if (!dn_ready) begin s_ovr = 1; mst = 0; end
               else if (mrem == 1) begin
                  mst = 0;
                  if (mlnk) begin
                     if (mq.size() > 0) m_take();
                     else s_unf = 1;
                  end
               end else mrem--;
            end
         end else if (!movr && mq.size() > 0) begin
            if (mq[0].imm) m_take();
            else if (mst == 0 && now > mq[0].t) begin
               void'(mq.pop_front()); s_late = 1;
            end else if (now >= mq[0].t) m_take();
            else mst = 1;
         end
         if (lat && !was_full) begin
            mcmd_t c;
            c.imm = mcmdw[31]; c.lnk = mcmdw[30]; c.cnt = mcmdw[29:0];
            c.t = {msec, cfg_data};
            mq.push_back(c);
         end
         if (cfg_stb && cfg_addr == 8'(BASE)) mcmdw = cfg_data;
         if (cfg_stb && cfg_addr == 8'(BASE + 1)) msec = cfg_data;
         mlate = (mlate && !lat) || s_late;
         munf  = (munf  && !lat) || s_unf;
         movr  = (movr  && !lat) || s_ovr;
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (!rst) begin
         logic [4:0] act, exp;
         act = {dn_valid, streaming, err_late, err_underflow, err_overrun};
         exp = {(mst == 2) && dsp_stb && dn_ready, mst == 2, mlate, munf, movr};
         n_chk++;
         if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (R12 cycle compare) {valid,stream,late,unf,ovr} actual=%b expected=%b",
                     cur_req, act, exp);
         end
         if (dn_valid) nvalid++;
      end
   end

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      cfg_stb = 1'b1; cfg_addr = a; cfg_data = d;
      @(posedge clk); #1;
      cfg_stb = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic send(int base, bit imm, bit lnk, int unsigned cnt, logic [63:0] t);
      wr(8'(base), {imm, lnk, cnt[29:0]});
      wr(8'(base + 1), t[63:32]);
      wr(8'(base + 2), t[31:0]);
   endtask

   initial begin
      idle(4);
      @(posedge clk); #1; rst = 1'b0;
      idle(1);
      // R13 reset state
      check("R13 streaming", streaming, 0);
      check("R13 flags", {err_late, err_underflow, err_overrun}, 0);
      check("R13 valid", dn_valid, 0);

      // R4 / R2: start-now command, count 5, strobe every cycle
      cur_req = "R4"; dsp_stb = 1; nvalid = 0;
      send(BASE, 1, 0, 5, 0);
      idle(12);
      check("R4 samples", nvalid, 5);
      check("R4 stopped", streaming, 0);

      // R1: the other channel's addresses are ignored
      cur_req = "R1"; nvalid = 0;
      send(32, 1, 0, 9, 0);
      idle(8);
      check("R1 foreign writes", nvalid, 0);
      wr(8'(BASE + 2), 0);   // replays staged word from the R4 step
      idle(10);
      check("R1 staging kept", nvalid, 5);

      // R5: timed start across the ticks wrap
      cur_req = "R5"; nvalid = 0;
      send(BASE, 0, 0, 3, now_time + 64'd25);
      idle(10);
      check("R5 not early", streaming, 0);
      check("R5 no samples yet", nvalid, 0);
      idle(30);
      check("R5 samples", nvalid, 3);

      // R6: start time already past
      cur_req = "R6"; nvalid = 0;
      send(BASE, 0, 0, 4, now_time - 64'd5);
      idle(5);
      check("R6 late flag", err_late, 1);
      check("R6 no samples", nvalid, 0);

      // R8 / R9 / R11: linked pair, then nothing
      cur_req = "R8"; dsp_stb = 0; nvalid = 0;
      send(BASE, 1, 1, 3, 0);
      check("R11 late cleared", err_late, 0);
      send(BASE, 0, 1, 4, 64'hFFFF_FFFF_0000_0000);
      dsp_stb = 1;
      idle(15);
      check("R8 linked samples", nvalid, 7);
      check("R9 underflow", err_underflow, 1);

      // R7: stop command alone and as the linked successor
      cur_req = "R7"; nvalid = 0;
      send(BASE, 1, 0, 0, 0);
      idle(3);
      check("R7 no stream", streaming, 0);
      check("R7 no samples", nvalid, 0);
      dsp_stb = 0;
      send(BASE, 1, 1, 3, 0);
      send(BASE, 1, 0, 0, 0);
      dsp_stb = 1;
      idle(10);
      check("R7 stop after link", nvalid, 3);
      check("R7 no underflow", err_underflow, 0);

      // R10: overrun halts streaming until the next latch
      cur_req = "R10"; nvalid = 0;
      send(BASE, 1, 0, 10, 0);
      idle(3);
      dn_ready = 0; idle(1); dn_ready = 1;
      idle(6);
      check("R10 overrun", err_overrun, 1);
      check("R10 halted", streaming, 0);
      nvalid = 0;
      send(BASE, 1, 0, 2, 0);
      idle(8);
      check("R10 cleared", err_overrun, 0);
      check("R10 resumed", nvalid, 2);

      // R3: fifth timed command into a full queue is dropped
      cur_req = "R3"; dsp_stb = 0; nvalid = 0;
      begin
         logic [63:0] t0;
         t0 = now_time + 64'd40;
         for (int k = 0; k < 5; k++) send(BASE, 0, 0, 1, t0 + 64'(10 * k));
      end
      dsp_stb = 1;
      idle(70);
      check("R3 full drop", nvalid, 4);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(4ns * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule